// File: doc/BRIEF.md
# Multiplexed Address/Data Bus Memory Target

This block is the memory side of a processor system bus on which addresses and data share one 64-bit path, and a separate 9-bit command bus tags every cycle. The block watches the command bus to tell an address cycle from a data cycle. From an address cycle it takes the transaction kind (read or write), whether the transfer is a single datum or a whole cache line, and the byte count. It then moves data to or from a small synchronous memory held inside the block.

A single-datum transfer carries 1 to 8 bytes. The block derives the byte enables from the low address bits and the byte count. A line transfer moves 32 bytes: four beats on the 64-bit bus, or eight beats when the bus is strapped to 32-bit mode. The initiator may leave idle cycles between write data words, so only cycles tagged as data are taken. On reads the block sets the pace itself and leaves a fixed number of idle cycles between returned words.

Every byte lane and the command bus carry even parity. The block checks parity on everything it receives and generates parity on everything it sends. A mismatch is reported but does not stop the transfer.

Top module: `muxbus_target`

## Requirements
- R1: A cycle is taken only when `validIn` is 1. `cmdIn[8]`=0 marks an address cycle and `cmdIn[8]`=1 marks a data cycle. An address cycle starts a transfer only while the block is idle and only when `cmdIn[7:5]` is 3'b000 (read) or 3'b001 (write). Other kinds, data cycles outside a write, and cycles with `validIn`=0 change neither memory nor the outputs.
- R2: In 64-bit mode, a single-datum write (`cmdIn[3]`=0) writes `cmdIn[2:0]`+1 bytes. It starts at byte lane `addr[2:0]` of word `addr>>3`. Bytes that would pass lane 7 are dropped.
- R3: In 32-bit mode (`mode32`=1), only `busIn[31:0]` and check bits [3:0] are used. A single write uses lanes `addr[1:0]` upward, with the count as in R2, cut off at lane 3. These lanes land in half `addr[2]` of the 64-bit word (half 1 = bits 63:32).
- R4: A line write (`cmdIn[3]`=1) fills the 32-byte line that holds the address. It takes 4 data beats in 64-bit mode and 8 in 32-bit mode. In 32-bit mode an even beat fills the low half and an odd beat the high half. Idle cycles between data beats are skipped.
- R5: A write data cycle with `cmdIn[0]`=1 ends the transfer, even in the middle of a line. Later data cycles are ignored.
- R6: A line read returns the words of the line in ascending order. Each beat has `busOutValid`=1 and `cmdOut[8]`=1. `cmdOut[0]`=1 appears only on the final beat, all other `cmdOut` bits are 0, and exactly READ_GAP idle cycles separate consecutive beats.
- R7: A single read returns one beat with `cmdOut`=9'h101. In 64-bit mode the beat is the whole word. In 32-bit mode it is half `addr[2]` on `busOut[31:0]`, with `busOut[63:32]`=0.
- R8: On every beat, each lane of `busOut` together with its bit of `busOutChk` has an even number of ones. `cmdOut` together with `cmdOutPar` also has an even number of ones.
- R9: A received cycle with a lane parity mismatch (active lanes only) or a command parity mismatch sets `parErrPulse` for exactly one cycle, in the cycle after it. It also sets `parErrSticky`, which holds until reset. The transfer still completes.
- R10: During and right after reset, `busOutValid`, `busOut`, `cmdOut`, `parErrPulse` and `parErrSticky` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rstN | input | 1 | Active-low synchronous reset |
| mode32 | input | 1 | Static strap: 1 selects the 32-bit bus mode |
| validIn | input | 1 | Initiator drives a cycle this clock |
| cmdIn | input | 9 | Command tag of the incoming cycle |
| cmdInPar | input | 1 | Even parity bit of cmdIn |
| busIn | input | 64 | Incoming address or data |
| busInChk | input | 8 | Even parity bit per incoming byte lane |
| busOut | output | 64 | Returned read data |
| busOutChk | output | 8 | Even parity bit per outgoing byte lane |
| cmdOut | output | 9 | Command tag of the returned data cycle |
| cmdOutPar | output | 1 | Even parity bit of cmdOut |
| busOutValid | output | 1 | A read data beat is on busOut |
| parErrPulse | output | 1 | One-cycle parity error report |
| parErrSticky | output | 1 | Parity error seen since reset |

## Verification
Single writes come from a table of start lanes and byte counts. The table covers a single byte, transfers that stay inside one word and transfers that run off the top lane. Reading each word back separates correct enable generation from off-by-one and wrap-around errors. Line writes are sent with two idle cycles after every pair of data beats, which shows whether untagged cycles are taken. Line reads check beat order, the end marker and the spacing between beats. Further patterns cover an early end marker, unsupported command kinds, unvalidated cycles, the 32-bit half selection, and single bad lane or command parity bits, and each tells apart the mode, the sequence or the error path it aims at.

// File: rtl/mbt_pkg.sv
package mbt_pkg;

  localparam logic [2:0] KIND_READ  = 3'b000;
  localparam logic [2:0] KIND_WRITE = 3'b001;

  typedef struct packed {
    logic       latchAddr;
    logic       wrEn;
    logic       rdLoad;
    logic       rdLast;
    logic       isBlock;
    logic [2:0] beat;
  } strobe_t;

  function automatic logic [7:0] enables64(input logic [2:0] start, input logic [2:0] sizeM1);
    logic [15:0] m;
    m = ((16'd1 << ({1'b0, sizeM1} + 4'd1)) - 16'd1) << start;
    return m[7:0];
  endfunction

  function automatic logic [3:0] enables32(input logic [1:0] start, input logic [2:0] sizeM1);
    logic [15:0] m;
    m = ((16'd1 << ({1'b0, sizeM1} + 4'd1)) - 16'd1) << start;
    return m[3:0];
  endfunction

  function automatic logic lanesEven(input logic [63:0] data, input logic [7:0] chk);
    logic ok;
    ok = 1'b1;
    for (int b = 0; b < 8; b++) begin
      if (^{data[b*8 +: 8], chk[b]}) ok = 1'b0;
    end
    return ok;
  endfunction

endpackage

// File: rtl/mbt_lane_parity.sv
module mbt_lane_parity #(
  parameter int LANES = 8
) (
  input  logic [LANES*8-1:0] data,
  output logic [LANES-1:0]   chk
);
  for (genvar g = 0; g < LANES; g++) begin : gLane
    assign chk[g] = ^data[g*8 +: 8];
  end
endmodule

// File: rtl/mbt_ctrl.sv
module mbt_ctrl
  import mbt_pkg::*;
#(
  parameter int READ_GAP = 1
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       mode32,
  input  logic       validIn,
  input  logic [8:0] cmdIn,
  output strobe_t    strobe
);
  localparam int GAPW = (READ_GAP > 0) ? $clog2(READ_GAP + 1) : 1;

  typedef enum logic [1:0] {S_IDLE, S_WRITE, S_READ} state_t;

  state_t        state;
  logic [2:0]    beat;
  logic          isBlock;
  logic [GAPW-1:0] gapCnt;

  logic       addrCycle, dataCycle, kindOk, atEnd;
  logic [2:0] lastBeatIdx;

  always_comb begin
    addrCycle   = validIn && !cmdIn[8];
    dataCycle   = validIn && cmdIn[8];
    kindOk      = (cmdIn[7:5] == KIND_READ) || (cmdIn[7:5] == KIND_WRITE);
    lastBeatIdx = mode32 ? 3'd7 : 3'd3;
    atEnd       = !isBlock || (beat == lastBeatIdx);

    strobe.latchAddr = (state == S_IDLE) && addrCycle && kindOk;
    strobe.wrEn      = (state == S_WRITE) && dataCycle;
    strobe.rdLoad    = (state == S_READ) && (gapCnt == '0);
    strobe.rdLast    = atEnd;
    strobe.isBlock   = isBlock;
    strobe.beat      = beat;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= S_IDLE;
      beat    <= '0;
      isBlock <= 1'b0;
      gapCnt  <= '0;
    end else begin
      case (state)
        S_IDLE: begin
          if (strobe.latchAddr) begin
            isBlock <= cmdIn[3];
            beat    <= '0;
            gapCnt  <= '0;
            state   <= (cmdIn[7:5] == KIND_WRITE) ? S_WRITE : S_READ;
          end
        end
        S_WRITE: begin
          if (dataCycle) begin
            if (cmdIn[0] || atEnd) state <= S_IDLE;
            else beat <= beat + 3'd1;
          end
        end
        S_READ: begin
          if (gapCnt == '0) begin
            if (atEnd) begin
              state <= S_IDLE;
            end else begin
              beat   <= beat + 3'd1;
              gapCnt <= GAPW'(READ_GAP);
            end
          end else begin
            gapCnt <= gapCnt - 1'b1;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  // R4: the beat index never passes the line length of the current mode
  a_r4_beat_range: assert property (@(posedge clk) disable iff (!rstN)
    (state != S_IDLE) |-> (beat <= lastBeatIdx));

  // R5: an end-marked write data cycle returns the block to idle
  a_r5_last_ends_write: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_WRITE && validIn && cmdIn[8] && cmdIn[0]) |=> (state == S_IDLE));

  // R1: a cycle without validIn never leaves idle
  a_r1_needs_valid: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_IDLE && !validIn) |=> (state == S_IDLE));

endmodule

// File: rtl/mbt_datapath.sv
module mbt_datapath
  import mbt_pkg::*;
#(
  parameter int MEM_WORDS = 32
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        mode32,
  input  logic        validIn,
  input  logic [63:0] busIn,
  input  logic [7:0]  busInChk,
  input  logic [8:0]  cmdIn,
  input  logic        cmdInPar,
  input  strobe_t     strobe,
  output logic [63:0] busOut,
  output logic [7:0]  busOutChk,
  output logic [8:0]  cmdOut,
  output logic        cmdOutPar,
  output logic        busOutValid,
  output logic        parErrPulse,
  output logic        parErrSticky
);
  localparam int IDXW = $clog2(MEM_WORDS);

  logic [63:0] mem [MEM_WORDS];
  logic [31:0] addrReg;
  logic [2:0]  sizeReg;

  logic [IDXW-1:0] wordIdx;
  logic            halfSel;
  logic [1:0]      beatPair;
  logic [7:0]      wrMask;
  logic [3:0]      mask4;
  logic [63:0]     wrData, rdWord, rdSel;
  logic [7:0]      outChk, inChk, laneBad;
  logic [8:0]      cmdNext;
  logic            anyErr;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrReg <= '0;
      sizeReg <= '0;
    end else if (strobe.latchAddr) begin
      addrReg <= busIn[31:0];
      sizeReg <= cmdIn[2:0];
    end
  end

  always_comb begin
    beatPair = mode32 ? strobe.beat[2:1] : strobe.beat[1:0];
    if (strobe.isBlock) begin
      wordIdx = {addrReg[IDXW+2:5], beatPair};
      halfSel = strobe.beat[0];
    end else begin
      wordIdx = addrReg[IDXW+2:3];
      halfSel = addrReg[2];
    end
    mask4 = enables32(addrReg[1:0], sizeReg);
    if (strobe.isBlock) wrMask = mode32 ? (halfSel ? 8'hF0 : 8'h0F) : 8'hFF;
    else if (mode32)    wrMask = halfSel ? {mask4, 4'h0} : {4'h0, mask4};
    else                wrMask = enables64(addrReg[2:0], sizeReg);
    wrData  = mode32 ? {busIn[31:0], busIn[31:0]} : busIn;
    rdWord  = mem[wordIdx];
    rdSel   = mode32 ? {32'h0, (halfSel ? rdWord[63:32] : rdWord[31:0])} : rdWord;
    cmdNext = {1'b1, 7'h00, strobe.rdLast};
  end

  always_ff @(posedge clk) begin
    if (strobe.wrEn) begin
      for (int b = 0; b < 8; b++) begin
        if (wrMask[b]) mem[wordIdx][b*8 +: 8] <= wrData[b*8 +: 8];
      end
    end
  end

  mbt_lane_parity #(.LANES(8)) u_outPar (.data(rdSel), .chk(outChk));
  mbt_lane_parity #(.LANES(8)) u_inPar  (.data(busIn), .chk(inChk));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busOut      <= '0;
      busOutChk   <= '0;
      cmdOut      <= '0;
      cmdOutPar   <= 1'b0;
      busOutValid <= 1'b0;
    end else if (strobe.rdLoad) begin
      busOut      <= rdSel;
      busOutChk   <= outChk;
      cmdOut      <= cmdNext;
      cmdOutPar   <= ^cmdNext;
      busOutValid <= 1'b1;
    end else begin
      busOut      <= '0;
      busOutChk   <= '0;
      cmdOut      <= '0;
      cmdOutPar   <= 1'b0;
      busOutValid <= 1'b0;
    end
  end

  always_comb begin
    laneBad = (inChk ^ busInChk) & (mode32 ? 8'h0F : 8'hFF);
    anyErr  = validIn && ((|laneBad) || ((^cmdIn) != cmdInPar));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      parErrPulse  <= 1'b0;
      parErrSticky <= 1'b0;
    end else begin
      parErrPulse  <= anyErr;
      parErrSticky <= parErrSticky | anyErr;
    end
  end

  // R8: every returned lane and the returned command have even parity
  a_r8_lane_parity: assert property (@(posedge clk) disable iff (!rstN)
    busOutValid |-> lanesEven(busOut, busOutChk));
  a_r8_cmd_parity: assert property (@(posedge clk) disable iff (!rstN)
    busOutValid |-> !(^{cmdOut, cmdOutPar}));

  // R7: upper lanes stay zero in 32-bit mode
  a_r7_upper_zero: assert property (@(posedge clk) disable iff (!rstN)
    (busOutValid && mode32) |-> (busOut[63:32] == 32'h0));

  // R6: the end-marked beat is followed by an idle cycle
  a_r6_last_then_idle: assert property (@(posedge clk) disable iff (!rstN)
    (busOutValid && cmdOut[0]) |=> !busOutValid);

  // R9: the sticky flag never clears and covers every pulse
  a_r9_sticky_holds: assert property (@(posedge clk) disable iff (!rstN)
    parErrSticky |=> parErrSticky);
  a_r9_pulse_sticky: assert property (@(posedge clk) disable iff (!rstN)
    parErrPulse |-> parErrSticky);

endmodule

// File: rtl/muxbus_target.sv
module muxbus_target
  import mbt_pkg::*;
#(
  parameter int MEM_WORDS = 32,
  parameter int READ_GAP  = 1
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        mode32,
  input  logic        validIn,
  input  logic [8:0]  cmdIn,
  input  logic        cmdInPar,
  input  logic [63:0] busIn,
  input  logic [7:0]  busInChk,
  output logic [63:0] busOut,
  output logic [7:0]  busOutChk,
  output logic [8:0]  cmdOut,
  output logic        cmdOutPar,
  output logic        busOutValid,
  output logic        parErrPulse,
  output logic        parErrSticky
);
  strobe_t strobe;

  mbt_ctrl #(.READ_GAP(READ_GAP)) u_ctrl (
    .clk(clk), .rstN(rstN), .mode32(mode32), .validIn(validIn),
    .cmdIn(cmdIn), .strobe(strobe)
  );

  mbt_datapath #(.MEM_WORDS(MEM_WORDS)) u_datapath (
    .clk(clk), .rstN(rstN), .mode32(mode32), .validIn(validIn),
    .busIn(busIn), .busInChk(busInChk), .cmdIn(cmdIn), .cmdInPar(cmdInPar),
    .strobe(strobe), .busOut(busOut), .busOutChk(busOutChk), .cmdOut(cmdOut),
    .cmdOutPar(cmdOutPar), .busOutValid(busOutValid),
    .parErrPulse(parErrPulse), .parErrSticky(parErrSticky)
  );

  // R10: no data beat while reset is held
  a_r10_reset_quiet: assert property (@(posedge clk)
    !rstN |=> !busOutValid);

endmodule

// File: tb/muxbus_target_bench.sv
module muxbus_target_bench;
  localparam int GAP   = 1;
  localparam int WORDS = 32;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        mode32 = 1'b0;
  logic        validIn = 1'b0;
  logic [8:0]  cmdIn = '0;
  logic        cmdInPar = 1'b0;
  logic [63:0] busIn = '0;
  logic [7:0]  busInChk = '0;
  logic [63:0] busOut;
  logic [7:0]  busOutChk;
  logic [8:0]  cmdOut;
  logic        cmdOutPar, busOutValid, parErrPulse, parErrSticky;

  always #10 clk = ~clk;

  muxbus_target #(.MEM_WORDS(WORDS), .READ_GAP(GAP)) u_muxbus_target (
    .clk(clk), .rstN(rstN), .mode32(mode32), .validIn(validIn),
    .cmdIn(cmdIn), .cmdInPar(cmdInPar), .busIn(busIn), .busInChk(busInChk),
    .busOut(busOut), .busOutChk(busOutChk), .cmdOut(cmdOut),
    .cmdOutPar(cmdOutPar), .busOutValid(busOutValid),
    .parErrPulse(parErrPulse), .parErrSticky(parErrSticky)
  );

  int nChk = 0;
  int nFail = 0;
  int cycleNo = 0;
  always @(posedge clk) cycleNo <= cycleNo + 1;

  // read beat monitor
  int          rxTotal = 0;
  logic [63:0] rxData [128];
  logic [7:0]  rxChk  [128];
  logic [8:0]  rxCmd  [128];
  logic        rxPar  [128];
  int          rxStamp[128];
  always @(negedge clk) begin
    if (busOutValid) begin
      rxData[rxTotal % 128]  = busOut;
      rxChk[rxTotal % 128]   = busOutChk;
      rxCmd[rxTotal % 128]   = cmdOut;
      rxPar[rxTotal % 128]   = cmdOutPar;
      rxStamp[rxTotal % 128] = cycleNo;
      rxTotal = rxTotal + 1;
    end
  end

  logic [63:0] model [WORDS];

  // single-write vector table (64-bit mode): address, count-1, data, expected byte mask
  localparam logic [31:0] VADDR [6] = '{32'h00, 32'h03, 32'h08, 32'h0D, 32'h16, 32'h1C};
  localparam logic [2:0]  VSIZE [6] = '{3'd0, 3'd1, 3'd7, 3'd2, 3'd3, 3'd0};
  localparam logic [63:0] VDATA [6] = '{64'h1122334455667788, 64'hAABBCCDDEEFF0011,
                                        64'h0F0E0D0C0B0A0908, 64'h7766554433221100,
                                        64'hCAFEBABE8BADF00D, 64'h0123456789ABCDEF};
  localparam logic [7:0]  VMASK [6] = '{8'h01, 8'h18, 8'hFF, 8'hE0, 8'hC0, 8'h10};

  function automatic logic [7:0] lanePar(input logic [63:0] d);
    logic [7:0] p;
    for (int b = 0; b < 8; b++) p[b] = ^d[b*8 +: 8];
    return p;
  endfunction

  function automatic logic [8:0] addrCmd(input logic [2:0] kind, input logic blk, input logic [2:0] sizeM1);
    return {1'b0, kind, 1'b0, blk, sizeM1};
  endfunction

  function automatic logic [8:0] dataCmd(input logic last);
    return {1'b1, 7'h00, last};
  endfunction

  function automatic logic [63:0] wdata(input logic [7:0] seed, input int b);
    return {8{seed ^ 8'(b * 37)}} ^ 64'h0F1E2D3C4B5A6978;
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic cyc(input logic v, input logic [8:0] cmd, input logic [63:0] d,
                     input logic [7:0] chkFlip, input logic cmdFlip);
    @(negedge clk);
    validIn  = v;
    cmdIn    = cmd;
    busIn    = d;
    busInChk = lanePar(d) ^ chkFlip;
    cmdInPar = (^cmd) ^ cmdFlip;
  endtask

  task automatic idle();
    cyc(1'b0, 9'h0, 64'h0, 8'h0, 1'b0);
  endtask

  function automatic logic [63:0] expandMask(input logic [7:0] m);
    logic [63:0] e;
    for (int b = 0; b < 8; b++) e[b*8 +: 8] = {8{m[b]}};
    return e;
  endfunction

  task automatic singleWrite(input logic [31:0] addr, input logic [2:0] sizeM1,
                             input logic [63:0] d, input logic [7:0] memMask);
    logic [63:0] dd, em;
    cyc(1'b1, addrCmd(3'b001, 1'b0, sizeM1), {32'h0, addr}, 8'h0, 1'b0);
    cyc(1'b1, dataCmd(1'b1), d, 8'h0, 1'b0);
    idle();
    dd = mode32 ? {d[31:0], d[31:0]} : d;
    em = expandMask(memMask);
    model[addr >> 3] = (model[addr >> 3] & ~em) | (dd & em);
  endtask

  // line write; idle cycles after every second beat; stops after beat stopAt with end marker
  task automatic lineWrite(input logic [31:0] addr, input logic [7:0] seed, input int stopAt);
    int nBeats;
    int wbase;
    logic [63:0] d;
    nBeats = mode32 ? 8 : 4;
    wbase  = (addr >> 3) & ~3;
    cyc(1'b1, addrCmd(3'b001, 1'b1, 3'd7), {32'h0, addr}, 8'h0, 1'b0);
    for (int b = 0; b <= stopAt; b++) begin
      d = wdata(seed, b);
      if (mode32) d[63:32] = 32'hDEADBEEF;
      cyc(1'b1, dataCmd(b == stopAt), d, 8'h0, 1'b0);
      if (mode32) begin
        if (b[0]) model[wbase + b/2][63:32] = d[31:0];
        else      model[wbase + b/2][31:0]  = d[31:0];
      end else begin
        model[wbase + b] = d;
      end
      if (b % 2 == 1) begin idle(); idle(); end
    end
    if (stopAt < nBeats - 1) begin
      // stray data cycle after the end marker must be ignored (R5)
      cyc(1'b1, dataCmd(1'b0), 64'hFFFF0000FFFF0000, 8'h0, 1'b0);
    end
    idle();
  endtask

  task automatic readBack(input logic [31:0] addr, input logic blk, input string req,
                          input logic cmdFlip);
    int base, n, wbase;
    logic [63:0] exp, w;
    logic half;
    base = rxTotal;
    n = blk ? (mode32 ? 8 : 4) : 1;
    wbase = blk ? ((addr >> 3) & ~3) : (addr >> 3);
    cyc(1'b1, addrCmd(3'b000, blk, 3'd7), {32'h0, addr}, 8'h0, cmdFlip);
    for (int t = 0; t < 60 && rxTotal < base + n; t++) idle();
    repeat (4) idle();
    check({req, " beat count"}, 64'(rxTotal - base), 64'(n));
    for (int i = 0; i < n && i < rxTotal - base; i++) begin
      if (blk) begin
        w = mode32 ? model[wbase + i/2] : model[wbase + i];
        half = mode32 ? i[0] : 1'b0;
      end else begin
        w = model[wbase];
        half = addr[2];
      end
      exp = mode32 ? {32'h0, (half ? w[63:32] : w[31:0])} : w;
      check({req, " data"}, rxData[(base + i) % 128], exp);
      check({req, " R6 cmd tag"}, 64'(rxCmd[(base + i) % 128]), 64'(dataCmd(i == n - 1)));
      check({req, " R8 lane parity"}, 64'(rxChk[(base + i) % 128]), 64'(lanePar(rxData[(base + i) % 128])));
      check({req, " R8 cmd parity"}, 64'(rxPar[(base + i) % 128]), 64'(^rxCmd[(base + i) % 128]));
      if (i > 0)
        check({req, " R6 beat spacing"}, 64'(rxStamp[(base + i) % 128] - rxStamp[(base + i - 1) % 128]), 64'(GAP + 1));
    end
  endtask

  bit done = 0;

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nChk++;
      nFail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", nChk, nFail);
      $finish;
    end
  end

  initial begin
    int base;
    // R10: reset state
    rstN = 1'b0;
    repeat (3) idle();
    check("R10 valid in reset", 64'(busOutValid), 64'd0);
    check("R10 data in reset", busOut, 64'h0);
    check("R10 sticky in reset", 64'(parErrSticky), 64'd0);
    @(negedge clk) rstN = 1'b1;
    idle();
    check("R10 cmdOut after reset", 64'(cmdOut), 64'd0);
    check("R10 pulse after reset", 64'(parErrPulse), 64'd0);

    // R4: fill lines 0..3 in 64-bit mode with idle cycles between beats
    for (int l = 0; l < 4; l++) lineWrite(32'(l * 32), 8'(8'h40 + l), 3);
    readBack(32'h00, 1'b1, "R4 R6 line0 64", 1'b0);
    readBack(32'h60, 1'b1, "R4 R6 line3 64", 1'b0);

    // R2 R7: single-datum vector table
    for (int v = 0; v < 6; v++) begin
      singleWrite(VADDR[v], VSIZE[v], VDATA[v], VMASK[v]);
      readBack(VADDR[v], 1'b0, "R2 R7 single 64", 1'b0);
    end

    // R5: early end marker on beat 1 of line 1
    lineWrite(32'h20, 8'h99, 1);
    readBack(32'h20, 1'b1, "R5 early end", 1'b0);

    // R1: unsupported kind, stray data cycle, unvalidated address
    cyc(1'b1, addrCmd(3'b010, 1'b0, 3'd7), 64'h0, 8'h0, 1'b0);
    cyc(1'b1, dataCmd(1'b1), 64'hDEADDEADDEADDEAD, 8'h0, 1'b0);
    idle();
    cyc(1'b1, dataCmd(1'b1), 64'hBEEFBEEFBEEFBEEF, 8'h0, 1'b0);
    idle();
    readBack(32'h00, 1'b0, "R1 ignored kind", 1'b0);
    base = rxTotal;
    cyc(1'b0, addrCmd(3'b000, 1'b0, 3'd7), 64'h8, 8'h0, 1'b0);
    repeat (6) idle();
    check("R1 no beat without validIn", 64'(rxTotal - base), 64'd0);

    // R3 R4 R7: 32-bit mode
    mode32 = 1'b1;
    idle();
    lineWrite(32'h40, 8'h5C, 7);
    readBack(32'h40, 1'b1, "R4 R6 line2 32", 1'b0);
    singleWrite(32'h45, 3'd2, 64'hFFFFFFFF_A1B2C3D4, 8'hE0);
    readBack(32'h44, 1'b0, "R3 R7 single 32 high", 1'b0);
    singleWrite(32'h42, 3'd3, 64'h00000000_11223344, 8'h0C);
    readBack(32'h40, 1'b0, "R3 R7 single 32 low", 1'b0);
    readBack(32'h48, 1'b0, "R7 single 32 untouched", 1'b0);
    mode32 = 1'b0;
    idle();

    // R9: bad lane parity on a write data cycle
    cyc(1'b1, addrCmd(3'b001, 1'b0, 3'd7), 64'h18, 8'h0, 1'b0);
    cyc(1'b1, dataCmd(1'b1), 64'h5566778899AABBCC, 8'h04, 1'b0);
    idle();
    check("R9 pulse after bad lane", 64'(parErrPulse), 64'd1);
    idle();
    check("R9 pulse lasts one cycle", 64'(parErrPulse), 64'd0);
    check("R9 sticky set", 64'(parErrSticky), 64'd1);
    model[3] = 64'h5566778899AABBCC;
    readBack(32'h18, 1'b0, "R9 write not aborted", 1'b0);
    check("R9 sticky held", 64'(parErrSticky), 64'd1);

    // R10: reset clears sticky
    rstN = 1'b0;
    idle(); idle();
    @(negedge clk) rstN = 1'b1;
    idle();
    check("R10 sticky cleared", 64'(parErrSticky), 64'd0);

    // R9: bad command parity on a read address cycle; read still completes
    base = rxTotal;
    readBack(32'h08, 1'b0, "R9 cmd parity read", 1'b1);
    check("R9 sticky after cmd parity", 64'(parErrSticky), 64'd1);

    // R9: bad upper lane in 32-bit mode is not an error
    rstN = 1'b0;
    idle(); idle();
    @(negedge clk) rstN = 1'b1;
    mode32 = 1'b1;
    idle();
    cyc(1'b1, dataCmd(1'b0), 64'h0, 8'h80, 1'b0);
    idle();
    check("R9 upper lane ignored in 32-bit", 64'(parErrPulse), 64'd0);
    mode32 = 1'b0;

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChk, nFail);
    $finish;
  end

endmodule